// File: doc/BRIEF.md
# Disable Tone Detection Controller

This block holds the timing and state logic that decides, for one voice channel, when a network answer tone that asks for echo control to be switched off has been validly seen, and when that condition ends. Upstream analysis supplies per-sample flags for each of the two signal paths (receive side and send side): the tone is in band, a phase reversal has just occurred, and the low-band and high-band energies are under their release levels. All flags are sampled only on an 8 kHz sample strobe.

Each path has its own qualifier. One rule needs the tone for a long window with at least one phase reversal inside the unbroken tone run. The other rule needs only a shorter unbroken window. When either path qualifies, a sticky status bit is set. The status stays set when the tone goes away. It clears only after every quiet flag on both paths has held for a release window of consecutive samples. Each change of status latches an active-low interrupt request, which the host clears with a one-cycle acknowledge. In automatic mode the status also drives a bypass request to the canceller.

Top module: `dtone_ctrl`

## Requirements
- R1: While reset is held and right after it, det_status is 0, irq_n is 1 and bypass_req is 0.
- R2: With dur_only_mode = 1, det_status rises at the clock edge of the SHORT_TICKS-th consecutive strobe on which a path's tone flag is 1, and not before.
- R3: With dur_only_mode = 0, det_status rises at the LONG_TICKS-th consecutive tone strobe only if a reversal flag was seen with the tone during that run. Without a reversal it stays 0 however long the tone lasts.
- R4: With dur_only_mode = 0, once a path has LONG_TICKS or more consecutive tone strobes, the first strobe that carries both tone and reversal sets det_status at that edge.
- R5: A strobe on which a path's tone flag is 0 clears that path's run length and its reversal-seen memory.
- R6: The receive path and the send path qualify independently, and either one alone sets det_status.
- R7: Once det_status is set, it stays 1 after the tone flags drop, as long as any quiet flag is 0.
- R8: det_status clears at the edge of the REL_TICKS-th consecutive strobe on which all four quiet flags (both paths, low and high band) are 1. A strobe with any quiet flag at 0 restarts this count.
- R9: irq_n goes to 0 at the same edge where det_status rises or falls. It stays 0 until a cycle with irq_ack = 1 and no new status change, and returns to 1 at that edge.
- R10: bypass_req equals det_status when auto_mode = 1 and is 0 when auto_mode = 0.
- R11: On cycles with smp_tick = 0, the tone, reversal and quiet flags have no effect on det_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_tick | input | 1 | One-cycle strobe per audio sample |
| dur_only_mode | input | 1 | 1: duration-only rule, 0: long window plus reversal |
| auto_mode | input | 1 | 1: status drives the bypass request |
| irq_ack | input | 1 | Host clears the pending interrupt |
| rx_tone | input | 1 | Receive path: tone in band |
| rx_rev | input | 1 | Receive path: phase reversal this sample |
| rx_lo_quiet | input | 1 | Receive path: low-band energy below release level |
| rx_hi_quiet | input | 1 | Receive path: high-band energy below release level |
| tx_tone | input | 1 | Send path: tone in band |
| tx_rev | input | 1 | Send path: phase reversal this sample |
| tx_lo_quiet | input | 1 | Send path: low-band energy below release level |
| tx_hi_quiet | input | 1 | Send path: high-band energy below release level |
| det_status | output | 1 | Sticky detection status |
| irq_n | output | 1 | Latched interrupt request, active low |
| bypass_req | output | 1 | Request to move the canceller to bypass |

## Verification
The checker tests several rules on every cycle. A status rise must follow a strobe that carried a tone flag, and a status fall must follow a strobe with every quiet flag set. Each status change must leave the interrupt low, and the interrupt must stay low until an acknowledge. The status must not move on cycles without a strobe. The bypass request must never appear in external mode or without status. The exact strobe counts fall outside what a single-cycle property can show: firing at SHORT_TICKS or LONG_TICKS and not earlier, the reversal condition, the restart after a tone gap or a noisy sample, and the release window. The bench's tick-by-tick vector table and its directed scenarios cover these.

// File: rtl/dtone_pkg.sv
package dtone_pkg;
   localparam int NPATH = 2;

   typedef struct packed {
      logic tone;
      logic rev;
      logic lo_quiet;
      logic hi_quiet;
   } path_flags_t;
endpackage

// File: rtl/dtone_qual.sv
// Per-path qualifier: counts consecutive tone samples, remembers a reversal.
module dtone_qual #(
   parameter int LONG_TICKS  = 8000,
   parameter int SHORT_TICKS = 3200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic dur_only,
   input  logic tone,
   input  logic rev,
   output logic qual
);
   localparam int CW = $clog2(LONG_TICKS + 1);
   localparam logic [CW-1:0] LONG_C  = CW'(LONG_TICKS);
   localparam logic [CW-1:0] SHORT_C = CW'(SHORT_TICKS);

   logic [CW-1:0] run_cnt;
   logic [CW-1:0] run_inc;
   logic [CW-1:0] need;
   logic          rev_seen;

   // run length including the current sample, saturating at the long window
   assign run_inc = (run_cnt == LONG_C) ? run_cnt : run_cnt + 1'b1;
   assign need    = dur_only ? SHORT_C : LONG_C;
   assign qual    = tick & tone & (run_inc >= need) & (dur_only | rev_seen | rev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         rev_seen <= 1'b0;
      end else if (tick) begin
         if (tone) begin
            run_cnt  <= run_inc;
            rev_seen <= rev_seen | rev;
         end else begin
            run_cnt  <= '0;
            rev_seen <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dtone_release.sv
// Release timer: consecutive all-quiet samples while the status is held.
module dtone_release #(
   parameter int REL_TICKS = 3200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic armed,
   input  logic quiet,
   output logic done
);
   localparam int CW = $clog2(REL_TICKS + 1);
   localparam logic [CW-1:0] REL_C = CW'(REL_TICKS);

   logic [CW-1:0] q_cnt;
   logic [CW-1:0] q_inc;

   assign q_inc = (q_cnt == REL_C) ? q_cnt : q_cnt + 1'b1;
   assign done  = tick & armed & quiet & (q_inc >= REL_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_cnt <= '0;
      else if (!armed)
         q_cnt <= '0;
      else if (tick)
         q_cnt <= quiet ? q_inc : '0;
   end
endmodule

// File: rtl/dtone_irq.sv
// Latched interrupt request; a new event wins over an acknowledge.
module dtone_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic ack,
   output logic irq_n
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (evt)
         pend <= 1'b1;
      else if (ack)
         pend <= 1'b0;
   end

   assign irq_n = ~pend;
endmodule

// File: rtl/dtone_ctrl.sv
module dtone_ctrl #(
   parameter int LONG_TICKS  = 8000,
   parameter int SHORT_TICKS = 3200,
   parameter int REL_TICKS   = 3200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_tick,
   input  logic dur_only_mode,
   input  logic auto_mode,
   input  logic irq_ack,
   input  logic rx_tone,
   input  logic rx_rev,
   input  logic rx_lo_quiet,
   input  logic rx_hi_quiet,
   input  logic tx_tone,
   input  logic tx_rev,
   input  logic tx_lo_quiet,
   input  logic tx_hi_quiet,
   output logic det_status,
   output logic irq_n,
   output logic bypass_req
);
   import dtone_pkg::*;

   if (SHORT_TICKS < 1 || LONG_TICKS < SHORT_TICKS || REL_TICKS < 1) begin : g_bad_param
      $error("dtone_ctrl: need 1 <= SHORT_TICKS <= LONG_TICKS and REL_TICKS >= 1");
   end

   path_flags_t       flags [NPATH];
   logic [NPATH-1:0]  path_qual;
   logic [NPATH-1:0]  path_quiet;
   logic              all_quiet;
   logic              rel_done;
   logic              status_q;
   logic              status_nx;

   assign flags[0] = '{tone: rx_tone, rev: rx_rev, lo_quiet: rx_lo_quiet, hi_quiet: rx_hi_quiet};
   assign flags[1] = '{tone: tx_tone, rev: tx_rev, lo_quiet: tx_lo_quiet, hi_quiet: tx_hi_quiet};

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      dtone_qual #(
         .LONG_TICKS  (LONG_TICKS),
         .SHORT_TICKS (SHORT_TICKS)
      ) u_qual (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (smp_tick),
         .dur_only (dur_only_mode),
         .tone     (flags[p].tone),
         .rev      (flags[p].rev),
         .qual     (path_qual[p])
      );
      assign path_quiet[p] = flags[p].lo_quiet & flags[p].hi_quiet;
   end

   assign all_quiet = &path_quiet;

   dtone_release #(
      .REL_TICKS (REL_TICKS)
   ) u_rel (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (smp_tick),
      .armed (status_q),
      .quiet (all_quiet),
      .done  (rel_done)
   );

   // qualification has priority over release
   always_comb begin
      status_nx = status_q;
      if (|path_qual)
         status_nx = 1'b1;
      else if (rel_done)
         status_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 1'b0;
      else
         status_q <= status_nx;
   end

   dtone_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (status_nx ^ status_q),
      .ack   (irq_ack),
      .irq_n (irq_n)
   );

   assign det_status = status_q;
   assign bypass_req = status_q & auto_mode;
endmodule

// File: rtl/dtone_ctrl_chk.sv
module dtone_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic smp_tick,
   input logic dur_only_mode,
   input logic auto_mode,
   input logic irq_ack,
   input logic rx_tone,
   input logic rx_rev,
   input logic rx_lo_quiet,
   input logic rx_hi_quiet,
   input logic tx_tone,
   input logic tx_rev,
   input logic tx_lo_quiet,
   input logic tx_hi_quiet,
   input logic det_status,
   input logic irq_n,
   input logic bypass_req
);
   logic quiet_all;
   assign quiet_all = rx_lo_quiet & rx_hi_quiet & tx_lo_quiet & tx_hi_quiet;

   AST_RISE_ON_TONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det_status) |-> $past(smp_tick && (rx_tone || tx_tone))); // R2

   AST_FALL_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(det_status) |-> $past(smp_tick && quiet_all)); // R8

   AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(det_status) || $fell(det_status)) |-> !irq_n); // R9

   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !irq_ack) |=> !irq_n); // R9

   AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_tick |=> $stable(det_status)); // R11

   AST_BYPASS_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode |-> !bypass_req); // R10

   AST_BYPASS_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_req |-> det_status); // R10
endmodule

bind dtone_ctrl dtone_ctrl_chk u_chk (.*);

// File: tb/dtone_ctrl_test.sv
`timescale 1ns/100ps
module dtone_ctrl_test;
   localparam int LONG  = 10;
   localparam int SHORT = 4;
   localparam int REL   = 5;
   localparam int NVEC  = 43;

   // bits: [6] dur_only [5] rx_tone [4] rx_rev [3] tx_tone [2] tx_rev [1] all quiet [0] expected status
   // covers R2 R3 R4 R5 R6 R7 R8, one strobe per entry
   localparam logic [6:0] VEC [0:NVEC-1] = '{
      7'b1100000, 7'b1100000, 7'b1100000, 7'b1100001,             // R2 short rule on rx
      7'b1000001,                                                 // R7 held, tone gone
      7'b1000011, 7'b1000011, 7'b1000011, 7'b1000011,
      7'b1000001,                                                 // R8 restart on noise
      7'b1000011, 7'b1000011, 7'b1000011, 7'b1000011,
      7'b1000010,                                                 // R8 release
      7'b0001000, 7'b0001000, 7'b0001100, 7'b0001000, 7'b0001000,
      7'b0001000, 7'b0001000, 7'b0001000, 7'b0001000,
      7'b0001001,                                                 // R3 R6 long rule on tx
      7'b0000011, 7'b0000011, 7'b0000011, 7'b0000011, 7'b0000010,
      7'b0110000, 7'b0000000,                                     // R5 reversal lost in gap
      7'b0100000, 7'b0100000, 7'b0100000, 7'b0100000, 7'b0100000,
      7'b0100000, 7'b0100000, 7'b0100000, 7'b0100000, 7'b0100000,
      7'b0110001                                                  // R4 late reversal
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_tick = 1'b0, dur_only_mode = 1'b0, auto_mode = 1'b1, irq_ack = 1'b0;
   logic rx_tone = 1'b0, rx_rev = 1'b0, rx_lo_quiet = 1'b0, rx_hi_quiet = 1'b0;
   logic tx_tone = 1'b0, tx_rev = 1'b0, tx_lo_quiet = 1'b0, tx_hi_quiet = 1'b0;
   logic det_status, irq_n, bypass_req;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   dtone_ctrl #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .REL_TICKS(REL)) uut (.*);

   task automatic chk(input logic act, input logic exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // v: [5] dur_only [4] rx_tone [3] rx_rev [2] tx_tone [1] tx_rev [0] all quiet
   task automatic set_in(input logic [5:0] v);
      dur_only_mode = v[5];
      rx_tone = v[4]; rx_rev = v[3];
      tx_tone = v[2]; tx_rev = v[1];
      rx_lo_quiet = v[0]; rx_hi_quiet = v[0];
      tx_lo_quiet = v[0]; tx_hi_quiet = v[0];
   endtask

   task automatic do_tick(input logic [5:0] v);
      @(negedge clk);
      set_in(v);
      smp_tick = 1'b1;
      @(posedge clk);
      #1;
      smp_tick = 1'b0;
   endtask

   task automatic ack_irq();
      @(negedge clk);
      irq_ack = 1'b1;
      @(posedge clk);
      #1;
      irq_ack = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(det_status, 1'b0, "R1 status in reset");
      chk(irq_n, 1'b1, "R1 irq in reset");
      chk(bypass_req, 1'b0, "R1 bypass in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(det_status, 1'b0, "R1 status after reset");
      chk(irq_n, 1'b1, "R1 irq after reset");

      for (int i = 0; i < NVEC; i++) begin
         do_tick(VEC[i][6:1]);
         n_checks++;
         if (det_status !== VEC[i][0]) begin
            n_fails++;
            $display("FAIL R2-R8 table step %0d: actual %b expected %b", i, det_status, VEC[i][0]);
         end
      end

      // R10 bypass follows status only in automatic mode
      chk(bypass_req, 1'b1, "R10 auto bypass");
      @(negedge clk);
      auto_mode = 1'b0;
      #1;
      chk(bypass_req, 1'b0, "R10 external bypass");
      auto_mode = 1'b1;

      // R9 pending interrupt cleared by acknowledge
      chk(irq_n, 1'b0, "R9 pending");
      ack_irq();
      chk(irq_n, 1'b1, "R9 acked");

      // R11 quiet flags without strobes do nothing
      @(negedge clk);
      set_in(6'b000001);
      repeat (20) @(posedge clk);
      #1;
      chk(det_status, 1'b1, "R11 no strobe, no release");

      // R8 release, R9 interrupt on the falling edge
      for (int k = 0; k < REL - 1; k++) do_tick(6'b000001);
      chk(det_status, 1'b1, "R8 one short of window");
      chk(irq_n, 1'b1, "R9 no event yet");
      do_tick(6'b000001);
      chk(det_status, 1'b0, "R8 released");
      chk(irq_n, 1'b0, "R9 irq on release");
      repeat (4) @(posedge clk);
      #1;
      chk(irq_n, 1'b0, "R9 held until ack");
      ack_irq();
      chk(irq_n, 1'b1, "R9 cleared");

      // R11 tone without strobes does nothing
      @(negedge clk);
      set_in(6'b110000);
      repeat (20) @(posedge clk);
      #1;
      chk(det_status, 1'b0, "R11 no strobe, no detect");
      chk(irq_n, 1'b1, "R11 no event");

      // R10 external mode: status and irq but no bypass
      @(negedge clk);
      auto_mode = 1'b0;
      for (int k = 0; k < SHORT; k++) do_tick(6'b100100);
      chk(det_status, 1'b1, "R10 R6 tx short rule");
      chk(bypass_req, 1'b0, "R10 no bypass in external");
      chk(irq_n, 1'b0, "R9 irq on detect");

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(det_status, 1'b0, "R1 reset clears status");
      chk(irq_n, 1'b1, "R1 reset clears irq");
      @(negedge clk);
      rst_n = 1'b1;

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule